// File: doc/BRIEF.md
# Interrupt Enable, Software Reset and Vector Register Block

This block holds the interrupt controls of an event-sensing input module. A byte-wide register interface reaches two registers. The control register holds an interrupt-enable bit and a self-clearing software-reset trigger. The vector register holds eight bits of read/write storage. When the enable bit is set, the module is in enhanced mode and an event is pending, the active-low interrupt request line is driven low. During an interrupt-select cycle, the block presents the stored vector.

Writing a one to the trigger bit produces a single-cycle soft-reset pulse that the neighbouring blocks use to clear their own state. The enable bit and the vector are cleared only by the system reset, so a software reset leaves both intact.

Top module: `intr_ctl_top`

## Requirements
- R1: After system reset the enable bit is 0, the vector is 8'h00, irq_n is 1, soft_rst_pulse is 0 and a control-register read (reg_sel=0) returns 8'hFC.
- R2: A write to the control register (reg_sel=0) stores wr_data bit 0 as the enable bit, and the new value is visible on the next read.
- R3: A control-register read returns bits 7:2 as ones, bit 1 as zero and bit 0 as the enable bit.
- R4: A control write with wr_data bit 1 set raises soft_rst_pulse for exactly one clock, in the cycle after the write edge. A control write with bit 1 clear gives no pulse.
- R5: A control write that sets bit 1 also updates the enable bit from bit 0 on the same edge.
- R6: The soft-reset pulse changes neither the enable bit nor the vector.
- R7: When enable, enh_mode and evt_pending are all 1, irq_n goes low one clock later. It stays low while they remain 1 and returns high one clock after evt_pending clears.
- R8: While the enable bit is 0, irq_n stays 1 whatever evt_pending does.
- R9: While enh_mode is 0, irq_n stays 1 and interrupt-select cycles are not answered.
- R10: A write with reg_sel=1 stores all eight bits of the vector. A read with reg_sel=1 returns them.
- R11: While iack_strobe is 1 with the enable bit and enh_mode both 1, ack_valid is 1 and ack_data equals the vector in the same cycle. Otherwise ack_valid is 0 and ack_data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Active-low system reset |
| reg_sel | input | 1 | Register select: 0 control, 1 vector |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| enh_mode | input | 1 | Module is in enhanced mode |
| evt_pending | input | 1 | An event is pending |
| iack_strobe | input | 1 | Interrupt-select cycle in progress |
| irq_n | output | 1 | Active-low interrupt request |
| ack_valid | output | 1 | Vector is being served |
| ack_data | output | 8 | Vector served during interrupt-select |
| soft_rst_pulse | output | 1 | One-cycle software reset pulse |

## Verification
Two functions can land on the same edge: a single control write both fires the soft-reset trigger and rewrites the enable bit. The bench writes 8'h03 and 8'h02 over a known enable state and a known vector. It then checks that the pulse lasts one cycle, that the enable bit takes the written bit 0, and that the later pulse cycle leaves the enable bit and the vector untouched. A second overlap occurs when an interrupt-select strobe arrives while the request is asserted. Here the vector must appear in the same cycle without disturbing irq_n.

// File: rtl/intr_ctl_pkg.sv
package intr_ctl_pkg;
  localparam int REG_W   = 8;
  localparam int EN_BIT  = 0;
  localparam int TRG_BIT = 1;

  // Control-register image: upper bits fixed high, trigger reads low.
  function automatic logic [REG_W-1:0] ctrl_image(input logic en);
    logic [REG_W-1:0] v;
    v          = '1;
    v[TRG_BIT] = 1'b0;
    v[EN_BIT]  = en;
    return v;
  endfunction

  // Request condition for the interrupt line.
  function automatic logic irq_wanted(input logic en, input logic enh, input logic pend);
    return en & enh & pend;
  endfunction
endpackage

// File: rtl/intr_ctl_enable_reg.sv
module intr_ctl_enable_reg (
  input  logic       clk,
  input  logic       sys_rst_n,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_bits,
  output logic       en_q,
  output logic       soft_rst_pulse
);
  import intr_ctl_pkg::*;

  logic trig;
  assign trig = ctrl_wr & ctrl_bits[TRG_BIT];

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      en_q           <= 1'b0;
      soft_rst_pulse <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= ctrl_bits[EN_BIT];
      soft_rst_pulse <= trig & ~soft_rst_pulse;
    end
  end
endmodule

// File: rtl/intr_ctl_vector_reg.sv
module intr_ctl_vector_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         sys_rst_n,
  input  logic         vec_wr,
  input  logic [W-1:0] vec_in,
  output logic [W-1:0] vec_q
);
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)  vec_q <= '0;
    else if (vec_wr) vec_q <= vec_in;
  end
endmodule

// File: rtl/intr_ctl_irq_gen.sv
module intr_ctl_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         sys_rst_n,
  input  logic         en_q,
  input  logic         enh_mode,
  input  logic         evt_pending,
  input  logic         iack_strobe,
  input  logic [W-1:0] vec_q,
  output logic         irq_n,
  output logic         ack_valid,
  output logic [W-1:0] ack_data
);
  import intr_ctl_pkg::*;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) irq_n <= 1'b1;
    else            irq_n <= ~irq_wanted(en_q, enh_mode, evt_pending);
  end

  always_comb begin
    ack_valid = iack_strobe & en_q & enh_mode;
    ack_data  = ack_valid ? vec_q : '0;
  end
endmodule

// File: rtl/intr_ctl_top.sv
module intr_ctl_top (
  input  logic       clk,
  input  logic       sys_rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       enh_mode,
  input  logic       evt_pending,
  input  logic       iack_strobe,
  output logic       irq_n,
  output logic       ack_valid,
  output logic [7:0] ack_data,
  output logic       soft_rst_pulse
);
  import intr_ctl_pkg::*;

  logic             ctrl_wr;
  logic             vec_wr;
  logic             en_q;
  logic [REG_W-1:0] vec_q;

  assign ctrl_wr = wr_en & ~reg_sel;
  assign vec_wr  = wr_en &  reg_sel;

  intr_ctl_enable_reg u_en (
    .clk(clk), .sys_rst_n(sys_rst_n), .ctrl_wr(ctrl_wr),
    .ctrl_bits(wr_data[1:0]), .en_q(en_q), .soft_rst_pulse(soft_rst_pulse)
  );

  intr_ctl_vector_reg #(.W(REG_W)) u_vec (
    .clk(clk), .sys_rst_n(sys_rst_n), .vec_wr(vec_wr),
    .vec_in(wr_data), .vec_q(vec_q)
  );

  intr_ctl_irq_gen #(.W(REG_W)) u_irq (
    .clk(clk), .sys_rst_n(sys_rst_n), .en_q(en_q), .enh_mode(enh_mode),
    .evt_pending(evt_pending), .iack_strobe(iack_strobe), .vec_q(vec_q),
    .irq_n(irq_n), .ack_valid(ack_valid), .ack_data(ack_data)
  );

  assign rd_data = reg_sel ? vec_q : ctrl_image(en_q);
endmodule

// File: rtl/intr_ctl_chk.sv
module intr_ctl_chk (
  input logic       clk,
  input logic       sys_rst_n,
  input logic       reg_sel,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       enh_mode,
  input logic       evt_pending,
  input logic       ack_valid,
  input logic       irq_n,
  input logic       soft_rst_pulse,
  input logic       en_q,
  input logic [7:0] vec_q
);
  assert_pulse_one_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    soft_rst_pulse |=> !soft_rst_pulse);

  assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    soft_rst_pulse |-> $past(wr_en && !reg_sel && wr_data[1]));

  assert_keep_en_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (soft_rst_pulse && !(wr_en && !reg_sel)) |=> $stable(en_q));

  assert_keep_vec_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (soft_rst_pulse && !(wr_en && reg_sel)) |=> $stable(vec_q));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(irq_n) |-> $past(en_q && enh_mode && evt_pending));

  assert_ack_gate_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ack_valid |-> (enh_mode && en_q));

  assert_ctrl_read_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !reg_sel |-> (rd_data[7:1] == 7'b1111110));
endmodule

bind intr_ctl_top intr_ctl_chk chk_i (
  .clk(clk), .sys_rst_n(sys_rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .enh_mode(enh_mode),
  .evt_pending(evt_pending), .ack_valid(ack_valid), .irq_n(irq_n),
  .soft_rst_pulse(soft_rst_pulse), .en_q(en_q), .vec_q(vec_q)
);

// File: tb/intr_ctl_top_tb_top.sv
`timescale 1ns/1ps
module intr_ctl_top_tb_top;
  logic       clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       enh_mode = 1'b0;
  logic       evt_pending = 1'b0;
  logic       iack_strobe = 1'b0;
  logic       irq_n;
  logic       ack_valid;
  logic [7:0] ack_data;
  logic       soft_rst_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intr_ctl_top dut_i (
    .clk(clk), .sys_rst_n(sys_rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .enh_mode(enh_mode),
    .evt_pending(evt_pending), .iack_strobe(iack_strobe), .irq_n(irq_n),
    .ack_valid(ack_valid), .ack_data(ack_data), .soft_rst_pulse(soft_rst_pulse)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write; returns at the negedge after the write edge.
  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel; #1; d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b0, v); chk("R1 ctrl", v, 8'hFC);
    rd(1'b1, v); chk("R1 vec", v, 8'h00);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 pulse", {7'b0, soft_rst_pulse}, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    wr(1'b0, 8'hFD); rd(1'b0, v); chk("R2 R3 en=1", v, 8'hFD);
    chk("R4 no pulse", {7'b0, soft_rst_pulse}, 8'h00);
    wr(1'b0, 8'h00); rd(1'b0, v); chk("R2 en=0", v, 8'hFC);
  endtask

  task automatic t_vector;
    logic [7:0] v;
    wr(1'b1, 8'hA5); rd(1'b1, v); chk("R10 A5", v, 8'hA5);
    wr(1'b1, 8'h5A); rd(1'b1, v); chk("R10 5A", v, 8'h5A);
  endtask

  task automatic t_soft;
    logic [7:0] v;
    wr(1'b0, 8'h03);
    chk("R4 pulse high", {7'b0, soft_rst_pulse}, 8'h01);
    rd(1'b0, v); chk("R5 en set with trigger", v, 8'hFD);
    @(negedge clk);
    chk("R4 pulse one cycle", {7'b0, soft_rst_pulse}, 8'h00);
    rd(1'b0, v); chk("R6 en kept", v, 8'hFD);
    rd(1'b1, v); chk("R6 vec kept", v, 8'h5A);
    wr(1'b0, 8'h02);
    chk("R4 pulse again", {7'b0, soft_rst_pulse}, 8'h01);
    rd(1'b0, v); chk("R5 en cleared with trigger", v, 8'hFC);
    @(negedge clk);
    rd(1'b1, v); chk("R6 vec kept 2", v, 8'h5A);
    rd(1'b0, v); chk("R6 en kept 2", v, 8'hFC);
  endtask

  task automatic t_irq;
    wr(1'b0, 8'h01);
    enh_mode = 1'b1; evt_pending = 1'b1;
    #1 chk("R7 not yet", {7'b0, irq_n}, 8'h01);
    @(negedge clk); chk("R7 low", {7'b0, irq_n}, 8'h00);
    @(negedge clk); chk("R7 held", {7'b0, irq_n}, 8'h00);
    iack_strobe = 1'b1; #1;
    chk("R11 valid", {7'b0, ack_valid}, 8'h01);
    chk("R11 data", ack_data, 8'h5A);
    chk("R7 irq during ack", {7'b0, irq_n}, 8'h00);
    @(negedge clk); iack_strobe = 1'b0; #1;
    chk("R11 idle", {7'b0, ack_valid}, 8'h00);
    chk("R11 idle data", ack_data, 8'h00);
    evt_pending = 1'b0;
    @(negedge clk); chk("R7 release", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_disabled;
    wr(1'b0, 8'h00);
    evt_pending = 1'b1; iack_strobe = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 irq off", {7'b0, irq_n}, 8'h01);
    chk("R11 no ack disabled", {7'b0, ack_valid}, 8'h00);
    iack_strobe = 1'b0; evt_pending = 1'b0;
  endtask

  task automatic t_std_mode;
    wr(1'b0, 8'h01);
    enh_mode = 1'b0; evt_pending = 1'b1; iack_strobe = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 irq off", {7'b0, irq_n}, 8'h01);
    chk("R9 no ack", {7'b0, ack_valid}, 8'h00);
    chk("R9 ack data", ack_data, 8'h00);
    iack_strobe = 1'b0; evt_pending = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    sys_rst_n = 1'b1;
    @(negedge clk);
    t_ctrl();
    t_vector();
    t_soft();
    t_irq();
    t_disabled();
    t_std_mode();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule